// File: doc/BRIEF.md
# Stack-Microcoded 8-bit CPU Engine

This block runs the instruction set of a small 8-bit accumulator processor by interpreting each opcode with a short micro-program. An opcode byte is fetched from main memory at the program counter. Its entry point is read from a table in the lower half of a microcode ROM. The engine then steps through byte-wide micro-instructions held in the upper half of that ROM.

The micro-instructions move values between the visible registers (accumulator, X, Y, program counter, memory address register) and a small operand stack with 16-bit entries. They also do simple arithmetic on the stack top and can call shared subroutines, such as operand fetch or absolute address assembly. A return-address stack holds the return points, so addressing modes are written once and reused by many opcodes.

Main memory and the microcode ROM are both synchronous: an address presented in one cycle gives its data in the next. Decimal arithmetic, interrupts and processor status flags are not part of this engine.

Top module: `ucode_stack_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, the program counter is 0x0200, A, X and Y are 0x00, `mem_we` is low and `mem_addr` shows 0x0200.
- R2: An opcode fetch reads memory at the PC and increments the PC by one. It then reads the ROM byte at address {0, opcode} as an index, and the routine starts at ROM address {1, index}. This takes five cycles before the first micro-instruction fetch.
- R3: A micro-instruction byte carries its operation in bits 6:0 and a last flag in bit 7. The operation codes are: 0 no-op, 1 call, 2 push PC, 3 push address register, 4 push memory read data, 5 push A, 6 push X, 7 push Y, 8 pop to PC, 9 pop to address register, 10 pop to memory write, 11 pop to A, 12 pop to X, 13 pop to Y, 14 increment, 15 decrement, 16 add, 17 shift left by eight, 18 OR.
- R4: Each micro-instruction uses one ROM fetch cycle followed by one execute cycle. A call adds two cycles to read its target byte.
- R5: A push places the register value, zero-extended to 16 bits, on the operand stack. A pop into A, X or Y keeps the low byte. A pop into the PC or the address register keeps all 16 bits.
- R6: Increment, decrement and shift-left-by-eight replace the stack top. Add and OR pop two entries and push the result. All results wrap modulo 2^16.
- R7: Pop to memory write raises `mem_we` for exactly one cycle, with the popped low byte on `mem_wdata` and the address register on `mem_addr`.
- R8: Push memory read data pushes the byte stored at the address register, given that the address register was written by an earlier micro-instruction.
- R9: A call without the last flag jumps to ROM address {1, next byte} and saves the address just after that byte. A later micro-instruction with the last flag resumes there. Calls nest two deep by default.
- R10: A call with the last flag set jumps to its target without saving a return point, so the target's final micro-instruction ends the opcode.
- R11: A last-flagged micro-instruction with no saved return point ends the opcode, and the next cycle begins a new opcode fetch at the PC.
- R12: A no-op leaves every register and the memory port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Main memory address |
| mem_wdata | output | 8 | Main memory write data |
| mem_we | output | 1 | Main memory write enable |
| mem_rdata | input | 8 | Main memory read data, one cycle after the address |
| rom_addr | output | 9 | Microcode ROM address |
| rom_data | input | 8 | Microcode ROM data, one cycle after the address |
| acc_o | output | 8 | Accumulator |
| x_o | output | 8 | X index register |
| y_o | output | 8 | Y index register |
| pc_o | output | 16 | Program counter |

## Verification
Any fault in the sequencer shows up at the ports within a few cycles. A wrong micro-program counter or return point fetches the wrong ROM byte, so a register or the PC diverges at the next execute edge. A wrong stack entry appears when it is popped: as a bad register value, or as a wrong byte or address on a write strobe. A timing slip in the fetch/execute rhythm moves the register updates and write strobes by a cycle. This is why the reference model is compared with every visible register and the write strobe on every clock, not only at the end of the program.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

    localparam int UOP_W  = 7;
    localparam int LAST_B = 7;

    typedef enum logic [UOP_W-1:0] {
        UOP_NOP    = 7'd0,
        UOP_CALL   = 7'd1,
        UOP_LD_PC  = 7'd2,
        UOP_LD_ADR = 7'd3,
        UOP_LD_Q   = 7'd4,
        UOP_LD_A   = 7'd5,
        UOP_LD_X   = 7'd6,
        UOP_LD_Y   = 7'd7,
        UOP_ST_PC  = 7'd8,
        UOP_ST_ADR = 7'd9,
        UOP_ST_MEM = 7'd10,
        UOP_ST_A   = 7'd11,
        UOP_ST_X   = 7'd12,
        UOP_ST_Y   = 7'd13,
        UOP_INC    = 7'd14,
        UOP_DEC    = 7'd15,
        UOP_ADD    = 7'd16,
        UOP_SHL    = 7'd17,
        UOP_OR     = 7'd18
    } uop_e;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_WAIT_MEM,
        ST_LATCH,
        ST_WAIT_IDX,
        ST_READ_IDX,
        ST_UFETCH,
        ST_EXEC,
        ST_CALL_FETCH,
        ST_CALL_JUMP
    } state_e;

    typedef enum logic [2:0] {
        OS_HOLD,
        OS_PUSH,
        OS_POP,
        OS_POP2_PUSH,
        OS_REPLACE
    } os_cmd_e;

endpackage

// File: rtl/ucs_alu.sv
module ucs_alu
    import ucs_pkg::*;
#(
    parameter int W     = 16,
    parameter int SHIFT = 8
) (
    input  uop_e           uop,
    input  logic [W-1:0]   tos,
    input  logic [W-1:0]   nos,
    output logic [W-1:0]   res
);

    always_comb begin
        case (uop)
            UOP_INC: res = tos + W'(1);
            UOP_DEC: res = tos - W'(1);
            UOP_ADD: res = nos + tos;
            UOP_OR:  res = nos | tos;
            UOP_SHL: res = tos << SHIFT;
            default: res = tos;
        endcase
    end

endmodule

// File: rtl/ucs_opstack.sv
module ucs_opstack
    import ucs_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  os_cmd_e       cmd,
    input  logic [W-1:0]  wr_val,
    output logic [W-1:0]  tos,
    output logic [W-1:0]  nos
);

    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [PW-1:0]           sp;
    } os_t;

    os_t s_q, s_d;

    logic [PW-1:0] i_top, i_sec;

    always_comb begin
        i_top = s_q.sp - PW'(1);
        i_sec = s_q.sp - PW'(2);
        tos   = s_q.ent[i_top];
        nos   = s_q.ent[i_sec];
    end

    always_comb begin
        s_d = s_q;
        case (cmd)
            OS_PUSH: begin
                s_d.ent[s_q.sp] = wr_val;
                s_d.sp          = s_q.sp + PW'(1);
            end
            OS_POP: begin
                s_d.sp = i_top;
            end
            OS_POP2_PUSH: begin
                s_d.ent[i_sec] = wr_val;
                s_d.sp         = i_top;
            end
            OS_REPLACE: begin
                s_d.ent[i_top] = wr_val;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: a pushed value is the new top
    p_push_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == OS_PUSH |=> tos == $past(wr_val));

    // R6: an in-place operation rewrites the top only
    p_replace_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == OS_REPLACE |=> tos == $past(wr_val) && nos == $past(nos));

    // R6: a two-operand result sits on top, over the entry that was third
    p_pop2_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == OS_POP2_PUSH |=> tos == $past(wr_val));

endmodule

// File: rtl/ucs_retstack.sv
module ucs_retstack #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wr_val,
    output logic [W-1:0]  top,
    output logic          empty
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [CW-1:0]           cnt;
    } rs_t;

    rs_t s_q, s_d;

    logic [IW-1:0] i_top;

    always_comb begin
        i_top = IW'(s_q.cnt - CW'(1));
        empty = (s_q.cnt == '0);
        top   = empty ? s_q.ent[0] : s_q.ent[i_top];
    end

    always_comb begin
        s_d = s_q;
        if (push) begin
            if (s_q.cnt < CW'(DEPTH)) s_d.ent[IW'(s_q.cnt)] = wr_val;
            s_d.cnt = s_q.cnt + CW'(1);
        end else if (pop && !empty) begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: a saved return point is visible on top at the next cycle
    p_push_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !empty && top == $past(wr_val));

    // R9: push and pop are never requested together
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/ucode_stack_engine.sv
module ucode_stack_engine
    import ucs_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          OS_DEPTH = 4,
    parameter int          RS_DEPTH = 2,
    parameter logic [15:0] RESET_PC = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    output logic [8:0]        rom_addr,
    input  logic [7:0]        rom_data,
    output logic [7:0]        acc_o,
    output logic [7:0]        x_o,
    output logic [7:0]        y_o,
    output logic [15:0]       pc_o
);

    localparam int UADDR_W = DATA_W + 1;

    typedef struct packed {
        state_e              st;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   adr;
        logic [DATA_W-1:0]   acc;
        logic [DATA_W-1:0]   xr;
        logic [DATA_W-1:0]   yr;
        logic [DATA_W-1:0]   op;
        logic [UADDR_W-1:0]  upc;
    } regs_t;

    regs_t r_q, r_d;

    uop_e                uop;
    logic                last;
    os_cmd_e             os_cmd;
    logic [ADDR_W-1:0]   os_wr, tos, nos, alu_res;
    logic                rs_push, rs_pop, rs_empty;
    logic [UADDR_W-1:0]  rs_wr, rs_top;
    logic                we_d;
    logic [DATA_W-1:0]   wdata_d;

    assign uop  = uop_e'(rom_data[UOP_W-1:0]);
    assign last = rom_data[LAST_B];

    ucs_opstack #(.W(ADDR_W), .DEPTH(OS_DEPTH)) u_os (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (os_cmd),
        .wr_val (os_wr),
        .tos    (tos),
        .nos    (nos)
    );

    ucs_retstack #(.W(UADDR_W), .DEPTH(RS_DEPTH)) u_rs (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (rs_push),
        .pop    (rs_pop),
        .wr_val (rs_wr),
        .top    (rs_top),
        .empty  (rs_empty)
    );

    ucs_alu #(.W(ADDR_W), .SHIFT(DATA_W)) u_alu (
        .uop (uop),
        .tos (tos),
        .nos (nos),
        .res (alu_res)
    );

    always_comb begin
        r_d     = r_q;
        os_cmd  = OS_HOLD;
        os_wr   = '0;
        rs_push = 1'b0;
        rs_pop  = 1'b0;
        rs_wr   = '0;
        we_d    = 1'b0;
        wdata_d = '0;

        case (r_q.st)
            ST_FETCH:    r_d.st = ST_WAIT_MEM;
            ST_WAIT_MEM: r_d.st = ST_LATCH;
            ST_LATCH: begin
                r_d.op = mem_rdata;
                r_d.pc = r_q.pc + ADDR_W'(1);
                r_d.st = ST_WAIT_IDX;
            end
            ST_WAIT_IDX: r_d.st = ST_READ_IDX;
            ST_READ_IDX: begin
                r_d.upc = {1'b1, rom_data};
                r_d.st  = ST_UFETCH;
            end
            ST_UFETCH: r_d.st = ST_EXEC;
            ST_EXEC: begin
                r_d.upc = r_q.upc + UADDR_W'(1);
                r_d.st  = ST_UFETCH;
                case (uop)
                    UOP_CALL: begin
                        r_d.st = ST_CALL_FETCH;
                        if (!last) begin
                            rs_push = 1'b1;
                            rs_wr   = r_q.upc + UADDR_W'(2);
                        end
                    end
                    UOP_LD_PC:  begin os_cmd = OS_PUSH; os_wr = r_q.pc; end
                    UOP_LD_ADR: begin os_cmd = OS_PUSH; os_wr = r_q.adr; end
                    UOP_LD_Q:   begin os_cmd = OS_PUSH; os_wr = ADDR_W'(mem_rdata); end
                    UOP_LD_A:   begin os_cmd = OS_PUSH; os_wr = ADDR_W'(r_q.acc); end
                    UOP_LD_X:   begin os_cmd = OS_PUSH; os_wr = ADDR_W'(r_q.xr); end
                    UOP_LD_Y:   begin os_cmd = OS_PUSH; os_wr = ADDR_W'(r_q.yr); end
                    UOP_ST_PC:  begin os_cmd = OS_POP; r_d.pc  = tos; end
                    UOP_ST_ADR: begin os_cmd = OS_POP; r_d.adr = tos; end
                    UOP_ST_MEM: begin
                        os_cmd  = OS_POP;
                        we_d    = 1'b1;
                        wdata_d = tos[DATA_W-1:0];
                    end
                    UOP_ST_A:   begin os_cmd = OS_POP; r_d.acc = tos[DATA_W-1:0]; end
                    UOP_ST_X:   begin os_cmd = OS_POP; r_d.xr  = tos[DATA_W-1:0]; end
                    UOP_ST_Y:   begin os_cmd = OS_POP; r_d.yr  = tos[DATA_W-1:0]; end
                    UOP_INC, UOP_DEC, UOP_SHL: begin
                        os_cmd = OS_REPLACE;
                        os_wr  = alu_res;
                    end
                    UOP_ADD, UOP_OR: begin
                        os_cmd = OS_POP2_PUSH;
                        os_wr  = alu_res;
                    end
                    default: ;
                endcase
                if (last && uop != UOP_CALL) begin
                    if (rs_empty) begin
                        r_d.st = ST_FETCH;
                    end else begin
                        rs_pop  = 1'b1;
                        r_d.upc = rs_top;
                    end
                end
            end
            ST_CALL_FETCH: r_d.st = ST_CALL_JUMP;
            ST_CALL_JUMP: begin
                r_d.upc = {1'b1, rom_data};
                r_d.st  = ST_UFETCH;
            end
            default: r_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_FETCH;
            r_q.pc  <= ADDR_W'(RESET_PC);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_addr  = (r_q.st == ST_FETCH || r_q.st == ST_WAIT_MEM) ? r_q.pc : r_q.adr;
        mem_we    = we_d;
        mem_wdata = wdata_d;
        rom_addr  = (r_q.st == ST_WAIT_IDX) ? {1'b0, r_q.op} : r_q.upc;
        acc_o     = r_q.acc;
        x_o       = r_q.xr;
        y_o       = r_q.yr;
        pc_o      = r_q.pc;
    end

    // R1: first cycle out of reset starts an opcode fetch at the reset PC
    p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pc_o == RESET_PC && !mem_we);

    // R7: a memory write strobe lasts one cycle
    p_we_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4: every execute cycle follows a ROM fetch cycle
    p_exec_after_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_EXEC |-> $past(r_q.st) == ST_UFETCH);

    // R2: the opcode latch step advances the PC by one
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_WAIT_IDX |-> pc_o == $past(pc_o) + 16'd1);

    // R12: a no-op disturbs no visible register
    p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EXEC && uop == UOP_NOP && !last)
        |=> $stable(acc_o) && $stable(x_o) && $stable(y_o) && $stable(pc_o));

endmodule

// File: tb/ucode_stack_engine_test.sv
module ucode_stack_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [8:0]  rom_addr;
    logic [7:0]  rom_data;
    logic [7:0]  acc_o, x_o, y_o;
    logic [15:0] pc_o;

    always #4 clk = ~clk;

    ucode_stack_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .acc_o     (acc_o),
        .x_o       (x_o),
        .y_o       (y_o),
        .pc_o      (pc_o)
    );

    logic [7:0] ram [0:8191];
    logic [7:0] rom [0:511];

    // R3: micro-routines, bit 7 = last, bits 6:0 = operation code
    logic [7:0] ucode [0:52] = '{
        8'h02, 8'h09, 8'h02, 8'h0E, 8'h08, 8'h84,
        8'h01, 8'h00, 8'h01, 8'h00, 8'h11, 8'h12, 8'h89,
        8'h01, 8'h00, 8'h8B,
        8'h01, 8'h06, 8'h05, 8'h8A,
        8'h05, 8'h8C,
        8'h06, 8'h0E, 8'h8C,
        8'h01, 8'h06, 8'h06, 8'h8A,
        8'h05, 8'h8D,
        8'h07, 8'h0F, 8'h8D,
        8'h80,
        8'h01, 8'h06, 8'h04, 8'h05, 8'h10, 8'h8B,
        8'h01, 8'h06, 8'h04, 8'h05, 8'h12, 8'h8B,
        8'h81, 8'h31,
        8'h01, 8'h06, 8'h03, 8'h88
    };

    logic [7:0] prog [0:35] = '{
        8'hA9, 8'h2A, 8'h8D, 8'h00, 8'h1F, 8'hAA, 8'hE8, 8'h8E, 8'h01, 8'h1F,
        8'hA8, 8'h88, 8'hEA, 8'h6D, 8'h00, 8'h1F, 8'h0D, 8'h01, 8'h1F, 8'h8D,
        8'h02, 8'h1F, 8'hA9, 8'hFF, 8'h8D, 8'h03, 8'h1F, 8'h6D, 8'h03, 8'h1F,
        8'h8D, 8'h04, 8'h1F, 8'h4C, 8'h21, 8'h02
    };

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory and ROM: one process loads and serves them
    initial begin : memories
        for (int i = 0; i < 8192; i++) ram[i] = 8'h00;
        for (int i = 0; i < 512; i++)  rom[i] = 8'h00;
        for (int i = 0; i < 36; i++)   ram[16'h0200 + i] = prog[i];
        for (int i = 0; i < 53; i++)   rom[256 + i] = ucode[i];
        // R2: opcode index table in the lower ROM half
        rom[8'hA9] = 8'h0D; rom[8'h8D] = 8'h10; rom[8'hAA] = 8'h14;
        rom[8'hE8] = 8'h16; rom[8'h8E] = 8'h19; rom[8'hA8] = 8'h1D;
        rom[8'h88] = 8'h1F; rom[8'hEA] = 8'h22; rom[8'h6D] = 8'h23;
        rom[8'h0D] = 8'h29; rom[8'h4C] = 8'h2F;
        forever begin
            @(posedge clk);
            if (mem_we) ram[mem_addr[12:0]] <= mem_wdata;
            mem_rdata <= ram[mem_addr[12:0]];
            rom_data  <= rom[rom_addr];
        end
    end

    // behavioural reference: expected visible state after each edge
    logic [15:0] e_pc = 16'h0200, e_adr = 16'h0000, e_wa = 16'h0000;
    logic [7:0]  e_a = 8'h00, e_x = 8'h00, e_y = 8'h00, e_wd = 8'h00;
    logic        e_we = 1'b0;

    initial begin : ref_model
        logic [8:0]  upc, tgt;
        logic [7:0]  opc, b;
        logic [6:0]  code;
        logic        lst, in_op;
        logic [15:0] t1, t2;
        logic [15:0] os [$];
        logic [8:0]  rq [$];
        @(posedge rst_n);
        forever begin
            @(posedge clk); opc = ram[e_pc[12:0]];
            @(posedge clk);
            @(posedge clk); e_pc = e_pc + 16'd1;
            @(posedge clk);
            @(posedge clk); upc = {1'b1, rom[opc]};
            in_op = 1'b1;
            while (in_op) begin
                @(posedge clk);
                b = rom[upc]; code = b[6:0]; lst = b[7];
                if (code == 7'd10) begin
                    e_we = 1'b1; e_wd = os[$][7:0]; e_wa = e_adr;
                end
                @(posedge clk);
                e_we = 1'b0;
                if (code == 7'd1) begin
                    if (!lst) rq.push_back(upc + 9'd2);
                    tgt = {1'b1, rom[upc + 9'd1]};
                    @(posedge clk);
                    @(posedge clk);
                    upc = tgt;
                end else begin
                    case (code)
                        7'd2:  os.push_back(e_pc);
                        7'd3:  os.push_back(e_adr);
                        7'd4:  os.push_back({8'h00, ram[e_adr[12:0]]});
                        7'd5:  os.push_back({8'h00, e_a});
                        7'd6:  os.push_back({8'h00, e_x});
                        7'd7:  os.push_back({8'h00, e_y});
                        7'd8:  e_pc = os.pop_back();
                        7'd9:  e_adr = os.pop_back();
                        7'd10: t1 = os.pop_back();
                        7'd11: begin t1 = os.pop_back(); e_a = t1[7:0]; end
                        7'd12: begin t1 = os.pop_back(); e_x = t1[7:0]; end
                        7'd13: begin t1 = os.pop_back(); e_y = t1[7:0]; end
                        7'd14: os[$] = os[$] + 16'd1;
                        7'd15: os[$] = os[$] - 16'd1;
                        7'd16: begin t1 = os.pop_back(); t2 = os.pop_back(); os.push_back(t2 + t1); end
                        7'd17: os[$] = {os[$][7:0], 8'h00};
                        7'd18: begin t1 = os.pop_back(); t2 = os.pop_back(); os.push_back(t2 | t1); end
                        default: ;
                    endcase
                    if (lst) begin
                        if (rq.size() == 0) in_op = 1'b0;
                        else upc = rq.pop_back();
                    end else begin
                        upc = upc + 9'd1;
                    end
                end
            end
        end
    end

    logic seen_first = 1'b0;
    logic seen_last  = 1'b0;

    // per-clock comparison: R2 R4 R5 R6 R8 R9 R10 R11 R12
    initial begin : compare
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            chk("R4 R5 R6 R8 R9 acc", {24'h0, acc_o}, {24'h0, e_a});
            chk("R5 R6 R12 x", {24'h0, x_o}, {24'h0, e_x});
            chk("R5 R6 R12 y", {24'h0, y_o}, {24'h0, e_y});
            chk("R2 R9 R10 R11 pc", {16'h0, pc_o}, {16'h0, e_pc});
            chk("R7 R12 we", {31'h0, mem_we}, {31'h0, e_we});
            if (e_we) begin
                chk("R7 waddr", {16'h0, mem_addr}, {16'h0, e_wa});
                chk("R7 wdata", {24'h0, mem_wdata}, {24'h0, e_wd});
            end
            if (mem_we && mem_addr == 16'h1F00 && !seen_first) begin
                seen_first = 1'b1;
                chk("R2 pc after store", {16'h0, pc_o}, 32'h0205);
                chk("R5 acc after load", {24'h0, acc_o}, 32'h2A);
                chk("R7 first write data", {24'h0, mem_wdata}, 32'h2A);
            end
            if (mem_we && mem_addr == 16'h1F04) seen_last = 1'b1;
        end
    end

    initial begin : main
        int guard;
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", {16'h0, pc_o}, 32'h0200);
        chk("R1 acc in reset", {24'h0, acc_o}, 32'h0);
        chk("R1 we in reset", {31'h0, mem_we}, 32'h0);
        chk("R1 addr in reset", {16'h0, mem_addr}, 32'h0200);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc after release", {16'h0, pc_o}, 32'h0200);
        guard = 0;
        while (!seen_last && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (!seen_last) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected program end");
        end
        repeat (300) @(negedge clk);
        chk("R7 ram 1F00", {24'h0, ram[13'h1F00]}, 32'h2A);
        chk("R6 R12 ram 1F01 inc", {24'h0, ram[13'h1F01]}, 32'h2B);
        chk("R6 R8 ram 1F02 or", {24'h0, ram[13'h1F02]}, 32'h7F);
        chk("R5 ram 1F03", {24'h0, ram[13'h1F03]}, 32'hFF);
        chk("R6 ram 1F04 add wrap", {24'h0, ram[13'h1F04]}, 32'hFE);
        chk("R6 final acc", {24'h0, acc_o}, 32'hFE);
        chk("R6 final y dec", {24'h0, y_o}, 32'h29);
        chk("R3 R10 R11 loop pc range", {31'h0, (pc_o >= 16'h0221 && pc_o <= 16'h0224)}, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule